// File: doc/BRIEF.md
# Bus Hold Request Handshake

This block decides who drives the external bus: the processor or another bus master that asks for it with a hold request. The request is registered on the rising clock edge. A transfer that is already running on the bus always finishes first. After that the block raises a hold acknowledge. One clock later it raises a float enable, which the pad logic uses to put the address, data, read strobe, write strobe and memory/IO select into high impedance.

While the bus is given away, the block tells the core that only new external bus cycles are stalled, so work inside the core carries on. When the request is withdrawn, the acknowledge drops on a rising edge. The float enable drops on the falling edge that follows, so the processor drives the bus again half a clock after the acknowledge falls. A core request for a new bus cycle is allowed to start only while the processor owns the bus and no hold request is pending.

Top module: `bus_hold_arbiter`

## Requirements
- R1: `hold_req_i` is registered on each rising clock edge. `hold_ack_o` rises on the first rising edge at which that registered copy is 1 and `xfer_busy_i` is 0. When the bus is idle, this is the second rising edge after the request is driven high.
- R2: While `xfer_busy_i` is 1, a pending hold request is deferred and `hold_ack_o` stays 0 until the transfer ends.
- R3: `bus_float_o` rises on the rising edge one clock after `hold_ack_o` rises. It then stays 1 as long as `hold_ack_o` stays 1.
- R4: Once `hold_ack_o` is 1, it stays 1 on every rising edge at which the registered request is still 1, whatever `xfer_busy_i` does.
- R5: `hold_ack_o` falls on the first rising edge at which the registered request is 0. This is the second rising edge after the request is withdrawn.
- R6: `bus_float_o` falls on the falling clock edge half a clock after `hold_ack_o` falls. It is therefore still 1 just after that rising edge and 0 just after the next falling edge.
- R7: `ext_stall_o` is 1 from the rising edge at which `hold_ack_o` rises until `bus_float_o` falls, and 0 at all other times.
- R8: `cyc_start_o` is 1 exactly when `core_cyc_req_i` is 1, `xfer_busy_i` is 0, `ext_stall_o` is 0 and the registered hold request is 0. A pending hold request therefore takes precedence over a new core cycle.
- R9: While `rst_n` is 0, `hold_ack_o` and `bus_float_o` are 0, and this takes effect at once even in the middle of a clock. The hold request is ignored until the internal reset has been released on the second rising edge after `rst_n` rises. With the request held high throughout, `hold_ack_o` rises on the fourth rising edge after release.
- R10: If the request is withdrawn while `hold_ack_o` is 1 but before the float has taken effect, `hold_ack_o` falls on the next rising edge and `bus_float_o` is 1 only from that rising edge to the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req_i | input | 1 | Bus request from the external master |
| xfer_busy_i | input | 1 | Bus sequencer has a transfer in progress |
| core_cyc_req_i | input | 1 | Core asks to begin a new external bus cycle |
| hold_ack_o | output | 1 | Hold acknowledge to the external master |
| bus_float_o | output | 1 | Puts the address, data, strobes and memory/IO select into high impedance |
| ext_stall_o | output | 1 | Only external bus cycles of the core are stalled |
| cyc_start_o | output | 1 | The requested bus cycle may start |

## Verification
Each result is due at a fixed point after the stimulus:
- `hold_ack_o` moves two rising edges after a request change, or one rising edge after `xfer_busy_i` drops.
- `bus_float_o` rises one rising edge after the acknowledge and falls on the falling edge after the acknowledge drops.
- `cyc_start_o` follows its inputs in the same cycle.

The bench drives inputs 1 ns after a rising edge and checks the rising-edge results 3 ns after it, before the falling edge. It checks the float again 2 ns after the falling edge, so the half-clock return shows up as a 1 followed by a 0 within one cycle. Every expected value in the vector table was worked out from the edge counts above.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  // bit 0 : acknowledge driven, bit 1 : float armed on the rising edge
  typedef enum logic [1:0] {
    ST_OWN     = 2'b00,
    ST_GRANT   = 2'b01,
    ST_FLOATED = 2'b11,
    ST_RETURN  = 2'b10
  } hold_state_e;

  localparam int ACK_BIT   = 0;
  localparam int FLOAT_BIT = 1;
endpackage

// File: rtl/hold_rst_sync.sv
module hold_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/hold_grant_fsm.sv
module hold_grant_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic hold_req_i,
  input  logic xfer_busy_i,
  output logic hold_s_o,
  output logic hlda_o,
  output logic float_arm_o
);
  hold_state_e state_q, state_d;
  logic        hold_s_q;
  logic [1:0]  state_bits;

  // request sampler
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_s_q <= 1'b0;
    else             hold_s_q <= hold_req_i;
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN, ST_RETURN:
        state_d = (hold_s_q && !xfer_busy_i) ? ST_GRANT : ST_OWN;
      ST_GRANT, ST_FLOATED:
        state_d = hold_s_q ? ST_FLOATED : ST_RETURN;
      default:
        state_d = ST_OWN;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_OWN;
    else             state_q <= state_d;
  end

  assign state_bits  = state_q;
  assign hold_s_o    = hold_s_q;
  assign hlda_o      = state_bits[ACK_BIT];
  assign float_arm_o = state_bits[FLOAT_BIT];
endmodule

// File: rtl/hold_float_ctl.sv
module hold_float_ctl (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic hlda_i,
  input  logic float_arm_i,
  output logic float_o
);
  logic hlda_neg_q;

  // falling-edge copy of the acknowledge: gives the half-clock return
  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hlda_neg_q <= 1'b0;
    else             hlda_neg_q <= hlda_i;
  end

  assign float_o = float_arm_i & hlda_neg_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_i,
  input  logic xfer_busy_i,
  input  logic core_cyc_req_i,
  output logic hold_ack_o,
  output logic bus_float_o,
  output logic ext_stall_o,
  output logic cyc_start_o
);
  logic rst_sync_n;
  logic hold_s;
  logic float_arm;

  hold_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hold_grant_fsm u_fsm (
    .clk         (clk),
    .rst_sync_n  (rst_sync_n),
    .hold_req_i  (hold_req_i),
    .xfer_busy_i (xfer_busy_i),
    .hold_s_o    (hold_s),
    .hlda_o      (hold_ack_o),
    .float_arm_o (float_arm)
  );

  hold_float_ctl u_flt (
    .clk         (clk),
    .rst_sync_n  (rst_sync_n),
    .hlda_i      (hold_ack_o),
    .float_arm_i (float_arm),
    .float_o     (bus_float_o)
  );

  assign ext_stall_o = hold_ack_o | bus_float_o;
  assign cyc_start_o = core_cyc_req_i & ~xfer_busy_i & ~ext_stall_o & ~hold_s;
endmodule

// File: rtl/bus_hold_arbiter_checker.sv
module bus_hold_arbiter_checker (
  input logic clk,
  input logic rst_sync_n,
  input logic hold_req_i,
  input logic xfer_busy_i,
  input logic hold_ack_o,
  input logic bus_float_o,
  input logic cyc_start_o
);
  // R1 R2: acknowledge only after a registered request with the bus idle
  assert_ack_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_ack_o) |-> ($past(hold_req_i, 2) && !$past(xfer_busy_i)));

  // R3: float first seen only after a full clock of acknowledge
  assert_float_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_float_o) |-> (hold_ack_o && $past(hold_ack_o)));

  // R4: acknowledge kept while the registered request stays high
  assert_ack_held_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hold_ack_o && $past(hold_req_i)) |=> hold_ack_o);

  // R5: acknowledge drops only after the request was withdrawn
  assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(hold_ack_o) |-> !$past(hold_req_i, 2));

  // R8: no cycle starts while a registered request is pending
  assert_no_start_pending_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cyc_start_o |-> !$past(hold_req_i));

  // R9: quiet outputs during reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_sync_n |-> (!hold_ack_o && !bus_float_o));
endmodule

bind bus_hold_arbiter bus_hold_arbiter_checker u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .hold_req_i  (hold_req_i),
  .xfer_busy_i (xfer_busy_i),
  .hold_ack_o  (hold_ack_o),
  .bus_float_o (bus_float_o),
  .cyc_start_o (cyc_start_o)
);

// File: tb/bus_hold_arbiter_test.sv
`timescale 1ns/1ps
module bus_hold_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic hold_req = 1'b0;
  logic busy = 1'b0;
  logic creq = 1'b0;
  logic ack, flt, stall, start;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_hold_arbiter uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold_req_i     (hold_req),
    .xfer_busy_i    (busy),
    .core_cyc_req_i (creq),
    .hold_ack_o     (ack),
    .bus_float_o    (flt),
    .ext_stall_o    (stall),
    .cyc_start_o    (start)
  );

  // {hold, busy, req | ack, float@rise, float@fall, stall, start}
  localparam int NV = 23;
  localparam logic [7:0] VEC [NV] = '{
    8'b001_00001,  // v0  R8 start when owned
    8'b110_00000,  // v1
    8'b111_00000,  // v2  R8 pending request blocks start
    8'b101_00000,  // v3  R2 deferred by busy
    8'b101_10010,  // v4  R1 ack, R7 stall
    8'b101_11110,  // v5  R3 float one clock later
    8'b001_11110,  // v6  R4
    8'b001_11110,  // v7
    8'b001_01010,  // v8  R5 ack drops, R6 float drops at falling edge
    8'b001_00001,  // v9  R8 start resumes
    8'b011_00000,  // v10
    8'b110_00000,  // v11
    8'b110_00000,  // v12 R2
    8'b100_00000,  // v13
    8'b010_10010,  // v14 R1
    8'b011_11110,  // v15 R4 busy ignored once granted
    8'b001_01010,  // v16 R6
    8'b001_00001,  // v17
    8'b100_00000,  // v18
    8'b000_00000,  // v19
    8'b000_10010,  // v20 R10 grant
    8'b001_01010,  // v21 R10 half-clock float only
    8'b001_00001   // v22
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk(ack, 1'b0, "R9 reset ack");
    chk(flt, 1'b0, "R9 reset float");
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1;
      hold_req = VEC[i][7];
      busy     = VEC[i][6];
      creq     = VEC[i][5];
      #2;
      chk(ack,   VEC[i][4], $sformatf("R1/R2/R4/R5 ack v%0d", i));
      chk(flt,   VEC[i][3], $sformatf("R3 float rise v%0d", i));
      chk(stall, VEC[i][1], $sformatf("R7 stall v%0d", i));
      chk(start, VEC[i][0], $sformatf("R8 start v%0d", i));
      @(negedge clk);
      #2;
      chk(flt,   VEC[i][2], $sformatf("R6 R10 float fall v%0d", i));
    end

    // R9: asynchronous reset while floated, request ignored during reset
    @(posedge clk); #1; hold_req = 1'b1; busy = 1'b0; creq = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    chk(flt, 1'b1, "R9 float before reset");
    rst_n = 1'b0;
    #1;
    chk(ack, 1'b0, "R9 async clear ack");
    chk(flt, 1'b0, "R9 async clear float");
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #3;
      chk(ack, 1'b0, "R9 hold ignored in reset");
    end
    @(posedge clk); #1; rst_n = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(posedge clk); #3;
      chk(ack, (c == 4), $sformatf("R9 ack after release edge %0d", c));
    end
    @(posedge clk); #1; hold_req = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    chk(ack, 1'b0, "R5 ack dropped at end");
    chk(flt, 1'b0, "R6 float dropped at end");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule